// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block gathers up to fifteen interrupt requests for a small 8-bit processor core and picks the one to service under a fixed priority. Each request has a latch bit. A latch bit is set by a one-cycle pulse from an on-chip peripheral, by an edge on one of two external port pins, or by software through the register bus. Each request bit has a matching mask bit. A master enable gates every request.

When the core retires an instruction, the block samples the masked requests and captures the most urgent one. It presents that request as a pending flag, an index and a vector address. The core acknowledges the request it is servicing. The acknowledge clears that request and drops the master enable. Separate strobes for enable, disable and interrupt return drive the master enable. The edges that the pins react to come from a small edge-select register. The block does not cover stacking or fetching the vector.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, the request and mask registers at 0xF8, 0xF9, 0xFA and 0xFB read 0x00. The edge-select register at 0xF7 reads 0x10. The pending output is 0.
- R2: The five registers at 0xF7–0xFB can be written and read back. Bit 7 of the first request register (0xFA) always reads 0 and ignores writes. Any other address reads 0x00.
- R3: While the master enable (bit 7 of 0xFB) is 0, the pending output never goes to 1.
- R4: Priority is fixed, with the lowest index highest. 0xFA bits 0–6 hold IRQ0–IRQ6 and 0xF8 bits 0–7 hold IRQ7–IRQ14. For a selected index n, the vector output is 2+2n.
- R5: The pending, index and vector outputs load only in the cycle after `retire` is high, or clear on an accepted acknowledge. Otherwise they hold their values.
- R6: A one-cycle pulse on `periph_set[n]` sets request bit n.
- R7: A bus write to a request register replaces all of that register's bits. A hardware set aimed at that register in the same cycle is lost. A hardware set aimed at the other request register still takes effect.
- R8: A request set by software is masked and prioritized exactly like a hardware request. A request whose mask bit is 0 stays latched but does not pend.
- R9: An acknowledge while pending clears the captured request bit, the master enable and the pending output. An acknowledge while not pending has no effect.
- R10: `ei_strobe` and `iret_strobe` set the master enable. `di_strobe` clears it. When `di_strobe` and `ei_strobe` arrive together, the enable is cleared.
- R11: The pins pass through a two-flop synchronizer and then edge detection. With the reset edge selection, a falling edge on `ext_pin[0]` sets IRQ1, a falling edge on `ext_pin[1]` sets IRQ3, and a rising edge on `ext_pin[0]` sets IRQ4. Edges are ignored until the synchronizer has filled after reset.
- R12: The edge-select register at 0xF7 holds a 2-bit mode for each of three pin channels. Bits 1:0 are the IRQ1 channel, bits 3:2 the IRQ3 channel and bits 5:4 the IRQ4 channel. The modes are 00 falling, 01 rising, 10 both and 11 off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| periph_set | input | 15 | Peripheral request pulses, one per IRQ |
| ext_pin | input | 2 | Asynchronous port pins |
| ei_strobe | input | 1 | Set the master enable |
| di_strobe | input | 1 | Clear the master enable |
| iret_strobe | input | 1 | Return from interrupt, set the master enable |
| retire | input | 1 | Instruction retire, samples requests |
| irq_ack | input | 1 | Acknowledge the captured request |
| irq_pending | output | 1 | An enabled, unmasked request was captured |
| irq_index | output | 4 | Captured request index |
| irq_vector | output | 8 | Vector address of the captured request |

## Verification
The bench builds the block with its default parameters: fifteen requests and a two-stage pin synchronizer. Fifteen requests spread the latches across both request registers, so a priority contest between the two registers can be staged. The same setup lets a software write hit one register while a hardware set lands in the other in the same cycle. With two synchronizer stages, pin edges appear in the request register three clocks after the pin changes, which the edge-mode tests rely on.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    localparam int NUM_IRQ     = 15;
    localparam int PRI_BITS    = 7;
    localparam int SEC_BITS    = NUM_IRQ - PRI_BITS;
    localparam int IDX_W       = $clog2(NUM_IRQ);
    localparam int NUM_PINS    = 2;
    localparam int NUM_EDGE_CH = 3;
    localparam int EDGE_W      = 2 * NUM_EDGE_CH;

    localparam logic [7:0] ADDR_MASK_A = 8'hFB;
    localparam logic [7:0] ADDR_REQ_A  = 8'hFA;
    localparam logic [7:0] ADDR_MASK_B = 8'hF9;
    localparam logic [7:0] ADDR_REQ_B  = 8'hF8;
    localparam logic [7:0] ADDR_EDGE   = 8'hF7;

    typedef enum logic [1:0] {
        EDGE_FALL = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_BOTH = 2'b10,
        EDGE_OFF  = 2'b11
    } edge_mode_e;

    // channel -> source pin and target request
    localparam int CH_PIN [NUM_EDGE_CH] = '{0, 1, 0};
    localparam int CH_IRQ [NUM_EDGE_CH] = '{1, 3, 4};
    localparam logic [EDGE_W-1:0] EDGE_RESET = 6'b01_00_00;

    typedef struct packed {
        logic [NUM_IRQ-1:0] req;
        logic [NUM_IRQ-1:0] mask;
        logic               master;
        logic [EDGE_W-1:0]  edge_sel;
        logic               pending;
        logic [IDX_W-1:0]   idx;
    } ctrl_state_t;

endpackage

// File: rtl/irq_pin_edge.sv
module irq_pin_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    localparam int WARM_LIM = SYNC_STAGES + 1;
    localparam int WARM_W   = $clog2(WARM_LIM + 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   last;
        logic [WARM_W-1:0]      warm;
    } edge_state_t;

    edge_state_t q, d;
    logic armed;
    logic level;

    always_comb begin
        d      = q;
        level  = q.sync[SYNC_STAGES-1];
        armed  = (q.warm == WARM_W'(WARM_LIM));
        d.sync = {q.sync[SYNC_STAGES-2:0], pin};
        d.last = level;
        if (!armed) d.warm = q.warm + 1'b1;
        rise   = armed &  level & ~q.last;
        fall   = armed & ~level &  q.last;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    a_r11_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise && fall));
    a_r11_rise_follows_low: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int N     = 15,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     active,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    logic [N:0]   seen;
    logic [N-1:0] grant;

    always_comb begin
        seen[0] = 1'b0;
        idx     = '0;
        for (int i = 0; i < N; i++) begin
            grant[i]  = active[i] & ~seen[i];
            seen[i+1] = seen[i] | active[i];
            if (grant[i]) idx = IDX_W'(i);
        end
        any = seen[N];
    end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [7:0]          bus_addr,
    input  logic                bus_wr,
    input  logic [7:0]          bus_wdata,
    output logic [7:0]          bus_rdata,
    input  logic [NUM_IRQ-1:0]  periph_set,
    input  logic [NUM_PINS-1:0] ext_pin,
    input  logic                ei_strobe,
    input  logic                di_strobe,
    input  logic                iret_strobe,
    input  logic                retire,
    input  logic                irq_ack,
    output logic                irq_pending,
    output logic [IDX_W-1:0]    irq_index,
    output logic [7:0]          irq_vector
);
    ctrl_state_t q, d;

    logic [NUM_PINS-1:0] pin_rise, pin_fall;
    logic [NUM_IRQ-1:0]  pin_set;
    logic [NUM_IRQ-1:0]  hw_set;
    logic [NUM_IRQ-1:0]  ack_clr;
    logic                any_act;
    logic [IDX_W-1:0]    enc_idx;
    logic                ack_fire;
    logic                wr_mask_a, wr_req_a, wr_mask_b, wr_req_b, wr_edge;

    // pin synchronizers and edge detectors
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        irq_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
            .clk  (clk),
            .rst_n(rst_n),
            .pin  (ext_pin[p]),
            .rise (pin_rise[p]),
            .fall (pin_fall[p])
        );
    end

    // per-channel edge mode selection
    logic [NUM_EDGE_CH-1:0] ch_hit;
    for (genvar c = 0; c < NUM_EDGE_CH; c++) begin : g_ch
        edge_mode_e mode;
        assign mode = edge_mode_e'(q.edge_sel[2*c +: 2]);
        always_comb begin
            unique case (mode)
                EDGE_FALL: ch_hit[c] = pin_fall[CH_PIN[c]];
                EDGE_RISE: ch_hit[c] = pin_rise[CH_PIN[c]];
                EDGE_BOTH: ch_hit[c] = pin_fall[CH_PIN[c]] | pin_rise[CH_PIN[c]];
                default:   ch_hit[c] = 1'b0;
            endcase
        end
    end

    always_comb begin
        pin_set = '0;
        for (int c = 0; c < NUM_EDGE_CH; c++)
            if (ch_hit[c]) pin_set[CH_IRQ[c]] = 1'b1;
    end

    irq_prio_enc #(.N(NUM_IRQ), .IDX_W(IDX_W)) u_enc (
        .active(q.req & q.mask),
        .any   (any_act),
        .idx   (enc_idx)
    );

    always_comb begin
        wr_mask_a = bus_wr && (bus_addr == ADDR_MASK_A);
        wr_req_a  = bus_wr && (bus_addr == ADDR_REQ_A);
        wr_mask_b = bus_wr && (bus_addr == ADDR_MASK_B);
        wr_req_b  = bus_wr && (bus_addr == ADDR_REQ_B);
        wr_edge   = bus_wr && (bus_addr == ADDR_EDGE);
        ack_fire  = irq_ack && q.pending;
        hw_set    = periph_set | pin_set;
        ack_clr   = '0;
        if (ack_fire) ack_clr[q.idx] = 1'b1;

        d = q;
        // request latches: ack clears, hardware sets, software write wins
        d.req = (q.req & ~ack_clr) | hw_set;
        if (wr_req_a) d.req[PRI_BITS-1:0]       = bus_wdata[PRI_BITS-1:0];
        if (wr_req_b) d.req[NUM_IRQ-1:PRI_BITS] = bus_wdata[SEC_BITS-1:0];

        if (wr_mask_a) d.mask[PRI_BITS-1:0]       = bus_wdata[PRI_BITS-1:0];
        if (wr_mask_b) d.mask[NUM_IRQ-1:PRI_BITS] = bus_wdata[SEC_BITS-1:0];
        if (wr_edge)   d.edge_sel                 = bus_wdata[EDGE_W-1:0];

        // master enable: clear beats set beats bus write
        if (ack_fire || di_strobe)        d.master = 1'b0;
        else if (ei_strobe || iret_strobe) d.master = 1'b1;
        else if (wr_mask_a)                d.master = bus_wdata[7];

        // capture on retire
        if (ack_fire) begin
            d.pending = 1'b0;
        end else if (retire) begin
            d.pending = q.master & any_act;
            d.idx     = enc_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.edge_sel <= EDGE_RESET;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        unique case (bus_addr)
            ADDR_MASK_A: bus_rdata = {q.master, q.mask[PRI_BITS-1:0]};
            ADDR_REQ_A:  bus_rdata = {1'b0, q.req[PRI_BITS-1:0]};
            ADDR_MASK_B: bus_rdata = q.mask[NUM_IRQ-1:PRI_BITS];
            ADDR_REQ_B:  bus_rdata = q.req[NUM_IRQ-1:PRI_BITS];
            ADDR_EDGE:   bus_rdata = {{(8-EDGE_W){1'b0}}, q.edge_sel};
            default:     bus_rdata = 8'h00;
        endcase
    end

    assign irq_pending = q.pending;
    assign irq_index   = q.idx;
    assign irq_vector  = {3'b000, q.idx, 1'b0} + 8'd2;

    // ---------------- assertions ----------------
    a_r3_no_pend_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_pending) |-> $past(q.master));
    a_r5_hold_without_retire: assert property (@(posedge clk) disable iff (!rst_n)
        (!retire && !irq_ack) |=> ($stable(irq_pending) && $stable(irq_index)));
    a_r7_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_REQ_B) |=> (q.req[NUM_IRQ-1:PRI_BITS] == $past(bus_wdata)));
    a_r9_ack_drops_master: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_pending) |=> (!q.master && !irq_pending));
    a_r10_di_clears: assert property (@(posedge clk) disable iff (!rst_n)
        di_strobe |=> !q.master);
    a_r6_periph_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_set[0] && !(bus_wr && bus_addr == ADDR_REQ_A)) |=> q.req[0]);
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_REQ_A) |-> !bus_rdata[7]);

endmodule

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;
    import irq_ctrl_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [14:0] periph_set = '0;
    logic [1:0]  ext_pin = 2'b11;
    logic        ei_strobe = 1'b0, di_strobe = 1'b0, iret_strobe = 1'b0;
    logic        retire = 1'b0, irq_ack = 1'b0;
    logic        irq_pending;
    logic [3:0]  irq_index;
    logic [7:0]  irq_vector;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } exp_item_t;
    exp_item_t sb_q[$];

    always #10 clk = ~clk;

    irq_prio_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .periph_set(periph_set),
        .ext_pin(ext_pin), .ei_strobe(ei_strobe), .di_strobe(di_strobe),
        .iret_strobe(iret_strobe), .retire(retire), .irq_ack(irq_ack),
        .irq_pending(irq_pending), .irq_index(irq_index), .irq_vector(irq_vector)
    );

    // driver side: queue an expectation
    task automatic expect_val(input logic [7:0] v, input string tag);
        exp_item_t it;
        it.exp = v;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // monitor side: pop and compare against an observed value
    task automatic observe(input logic [7:0] act);
        exp_item_t it;
        it = sb_q.pop_front();
        checks++;
        if (act !== it.exp) begin
            errors++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", it.tag, act, it.exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_check(input logic [7:0] a, input logic [7:0] v, input string tag);
        @(negedge clk);
        bus_addr = a;
        expect_val(v, tag);
        #1 observe(bus_rdata);
    endtask

    task automatic out_check(input logic p, input logic [3:0] i, input logic [7:0] vec,
                             input string tag);
        #1;
        expect_val({7'd0, p}, {tag, " pending"});
        observe({7'd0, irq_pending});
        if (p) begin
            expect_val({4'd0, i}, {tag, " index"});
            observe({4'd0, irq_index});
            expect_val(vec, {tag, " vector"});
            observe(irq_vector);
        end
    endtask

    task automatic do_retire();
        @(negedge clk) retire = 1'b1;
        @(negedge clk) retire = 1'b0;
    endtask

    task automatic do_ack();
        @(negedge clk) irq_ack = 1'b1;
        @(negedge clk) irq_ack = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        wait_cycles(4);
        rst_n = 1'b1;
        wait_cycles(6);

        // R1 reset state
        rd_check(8'hF8, 8'h00, "R1 req_b reset");
        rd_check(8'hF9, 8'h00, "R1 mask_b reset");
        rd_check(8'hFA, 8'h00, "R1 req_a reset");
        rd_check(8'hFB, 8'h00, "R1 mask_a reset");
        rd_check(8'hF7, 8'h10, "R1 edge reset");
        out_check(1'b0, 4'd0, 8'd0, "R1");

        // R2 access, reserved bit
        wr(8'hFB, 8'h7F);
        wr(8'hF9, 8'hFF);
        wr(8'hFA, 8'hFF);
        rd_check(8'hFA, 8'h7F, "R2 reserved bit7");
        rd_check(8'hF9, 8'hFF, "R2 mask_b readback");
        rd_check(8'h33, 8'h00, "R2 unmapped");

        // R3 master off
        do_retire();
        out_check(1'b0, 4'd0, 8'd0, "R3 master off");

        // R10 EI, R4/R8 software requests pend
        @(negedge clk) ei_strobe = 1'b1;
        @(negedge clk) ei_strobe = 1'b0;
        rd_check(8'hFB, 8'hFF, "R10 ei sets master");
        do_retire();
        out_check(1'b1, 4'd0, 8'h02, "R4 R8 irq0");

        // R9 ack
        do_ack();
        out_check(1'b0, 4'd0, 8'd0, "R9 ack");
        rd_check(8'hFA, 8'h7E, "R9 ack clears bit");
        rd_check(8'hFB, 8'h7F, "R9 ack clears master");

        // R10 IRET
        @(negedge clk) iret_strobe = 1'b1;
        @(negedge clk) iret_strobe = 1'b0;
        rd_check(8'hFB, 8'hFF, "R10 iret sets master");
        do_retire();
        out_check(1'b1, 4'd1, 8'h04, "R4 irq1");

        // R5 hold without retire
        wr(8'hFA, 8'h00);
        wait_cycles(2);
        out_check(1'b1, 4'd1, 8'h04, "R5 hold");
        do_retire();
        out_check(1'b0, 4'd0, 8'd0, "R5 resample");

        // R6 peripheral pulse
        @(negedge clk) periph_set = 15'd1 << 9;
        @(negedge clk) periph_set = '0;
        rd_check(8'hF8, 8'h04, "R6 periph sets irq9");
        do_retire();
        out_check(1'b1, 4'd9, 8'h14, "R6 R4 irq9");

        // R8 mask hides latched request
        wr(8'hF9, 8'h00);
        do_retire();
        out_check(1'b0, 4'd0, 8'd0, "R8 masked");
        rd_check(8'hF8, 8'h04, "R8 still latched");

        // R4 cross-register priority
        wr(8'hF9, 8'hFF);
        wr(8'hFA, 8'h08);
        do_retire();
        out_check(1'b1, 4'd3, 8'h08, "R4 irq3 over irq9");

        // R7 write wins on same cycle
        wr(8'hFA, 8'h00);
        @(negedge clk);
        bus_addr = 8'hF8; bus_wr = 1'b1; bus_wdata = 8'h00;
        periph_set = (15'd1 << 10) | 15'd1;
        @(negedge clk);
        bus_wr = 1'b0; periph_set = '0;
        rd_check(8'hF8, 8'h00, "R7 hw set lost");
        rd_check(8'hFA, 8'h01, "R7 other reg set kept");
        do_retire();
        out_check(1'b1, 4'd0, 8'h02, "R7 irq0 pends");
        do_ack();

        // R10 DI beats EI, R9 stray ack
        @(negedge clk) begin ei_strobe = 1'b1; di_strobe = 1'b1; end
        @(negedge clk) begin ei_strobe = 1'b0; di_strobe = 1'b0; end
        rd_check(8'hFB, 8'h7F, "R10 di wins");
        @(negedge clk) ei_strobe = 1'b1;
        @(negedge clk) ei_strobe = 1'b0;
        do_ack();
        rd_check(8'hFB, 8'hFF, "R9 stray ack ignored");
        @(negedge clk) di_strobe = 1'b1;
        @(negedge clk) di_strobe = 1'b0;
        rd_check(8'hFB, 8'h7F, "R10 di clears");

        // R11 default pin edges
        wr(8'hFA, 8'h00);
        @(negedge clk) ext_pin[0] = 1'b0;
        wait_cycles(5);
        rd_check(8'hFA, 8'h02, "R11 pin0 fall irq1");
        @(negedge clk) ext_pin[1] = 1'b0;
        wait_cycles(5);
        rd_check(8'hFA, 8'h0A, "R11 pin1 fall irq3");
        @(negedge clk) ext_pin[0] = 1'b1;
        wait_cycles(5);
        rd_check(8'hFA, 8'h1A, "R11 pin0 rise irq4");

        // R12 edge modes: ch0 off, ch1 both, ch2 falling
        wr(8'hF7, 8'h0B);
        rd_check(8'hF7, 8'h0B, "R2 R12 edge readback");
        wr(8'hFA, 8'h00);
        @(negedge clk) ext_pin[0] = 1'b0;
        wait_cycles(5);
        rd_check(8'hFA, 8'h10, "R12 ch2 falling, ch0 off");
        @(negedge clk) ext_pin[1] = 1'b1;
        wait_cycles(5);
        rd_check(8'hFA, 8'h18, "R12 ch1 both rise");
        @(negedge clk) ext_pin[0] = 1'b1;
        wait_cycles(5);
        rd_check(8'hFA, 8'h18, "R12 rise ignored");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule